// File: doc/BRIEF.md
# Integer multiply-add high/low unit

This execution unit takes three 64-bit operands A, B and C together with a 32-bit instruction word. It forms the full 128-bit product of A and B, widens C to 128 bits and adds the two. It then returns either the upper or the lower doubleword of that sum. A small decoder inside the unit reads the instruction word and picks one of three forms: signed high, unsigned high or low. Any other word is reported as an illegal operation.

The unit is a two-stage pipeline. It accepts a new operation in every cycle while `in_valid` is high. Each accepted operation produces a one-cycle `out_valid` strobe exactly two cycles later. The result register keeps its last value between strobes. An illegal operation still produces a strobe, with `out_illegal` set, and leaves the result unchanged.

Top module: `imadd_unit`

## Requirements
- R1: For every cycle with `in_valid` high, `out_valid` is high exactly two cycles later, and it is low otherwise. Back-to-back operations are accepted every cycle and complete in order.
- R2: Signed high form (bits 31:26 = 4, bits 5:0 = 0x30): `out_result` = bits 127:64 of (A*B as two's complement) + (C sign-extended to 128 bits).
- R3: Unsigned high form (bits 31:26 = 4, bits 5:0 = 0x31, so instruction bit 0 = 1 selects unsigned): `out_result` = bits 127:64 of (A*B unsigned) + (C zero-extended).
- R4: Low form (bits 31:26 = 4, bits 5:0 = 0x33): `out_result` = bits 63:0 of A*B + C. The value is the same for signed and unsigned operands.
- R5: The carry out of the low doubleword reaches the high doubleword. For unsigned A = B = C = 0xFFFF_FFFF_FFFF_FFFF, the high result is 0xFFFF_FFFF_FFFF_FFFF.
- R6: If bits 31:26 differ from 4, or if bits 5:0 are not 0x30, 0x31 or 0x33, the operation is illegal. It then gives `out_valid` = 1 with `out_illegal` = 1, and `out_result` keeps its previous value. For legal operations `out_illegal` = 0, and `out_illegal` is never high without `out_valid`.
- R7: While synchronous active-high `rst` is high, both pipeline valid bits clear. After reset, `out_valid` = 0 and `out_result` = 0.
- R8: While `out_valid` is low, `out_result` holds its value.
- R9: Signed corner case: A = B = 0x8000_0000_0000_0000 and C = -1 give a high result of 0x3FFF_FFFF_FFFF_FFFF, because the negative addend borrows out of the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| insn | input | 32 | Instruction word selecting the form |
| opa | input | 64 | Multiplicand A |
| opb | input | 64 | Multiplier B |
| opc | input | 64 | Addend C |
| out_valid | output | 1 | Result strobe, two cycles after acceptance |
| out_illegal | output | 1 | The completing operation was not recognised |
| out_result | output | 64 | Selected doubleword of the sum |

## Verification
The hardest case to reach is a sum whose low doubleword carries or borrows into the high doubleword. Random operands rarely produce it. The stimulus therefore forces it with all-ones unsigned operands and with the most negative signed operands plus a minus-one addend. Illegal words are placed directly between legal back-to-back operations, so the test shows that the result register is skipped for exactly that slot and still holds the right value afterwards.

// File: rtl/imadd_pkg.sv
package imadd_pkg;
   typedef enum logic [1:0] {
      OP_HIGH_S = 2'd0,
      OP_HIGH_U = 2'd1,
      OP_LOW    = 2'd2,
      OP_BAD    = 2'd3
   } mac_op_e;
endpackage

// File: rtl/imadd_decode.sv
module imadd_decode
   import imadd_pkg::*;
#(
   parameter int INSN_W  = 32,
   parameter int PRI_W   = 6,
   parameter int XO_W    = 6,
   parameter int PRI_VAL = 4,
   parameter int XO_HIGH = 6'h30,
   parameter int XO_LOW  = 6'h33
) (
   input  logic [INSN_W-1:0] insn,
   output mac_op_e           op
);
   localparam int MID_W = INSN_W - PRI_W - XO_W;

   if (MID_W < 1) begin : g_bad_width
      $error("imadd_decode: instruction word too narrow for its fields");
   end
   if ((XO_HIGH % 2) != 0) begin : g_bad_xo
      $error("imadd_decode: high-form code must have bit 0 clear");
   end

   logic [PRI_W-1:0] pri_f;
   logic [XO_W-1:0]  xo_f;
   logic             mid_unused;
   localparam logic [XO_W-1:0]  XO_H  = XO_W'(XO_HIGH);
   localparam logic [XO_W-1:0]  XO_L  = XO_W'(XO_LOW);
   localparam logic [PRI_W-1:0] PRI_C = PRI_W'(PRI_VAL);

   assign pri_f      = insn[INSN_W-1 -: PRI_W];
   assign xo_f       = insn[XO_W-1:0];
   assign mid_unused = ^insn[INSN_W-PRI_W-1:XO_W];

   always_comb begin
      op = OP_BAD;
      if (pri_f == PRI_C) begin
         if (xo_f[XO_W-1:1] == XO_H[XO_W-1:1])
            op = xo_f[0] ? OP_HIGH_U : OP_HIGH_S;
         else if (xo_f == XO_L)
            op = OP_LOW;
      end
   end
endmodule

// File: rtl/imadd_prod_stage.sv
module imadd_prod_stage
   import imadd_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  mac_op_e           op_in,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   input  logic [XLEN-1:0]   c,
   output logic              s1_valid,
   output mac_op_e           s1_op,
   output logic [2*XLEN-1:0] s1_prod,
   output logic [2*XLEN-1:0] s1_addend
);
   localparam int WW = 2 * XLEN;

   if (XLEN < 2) begin : g_bad_xlen
      $error("imadd_prod_stage: XLEN must be at least 2");
   end

   logic          sgn;
   logic [WW-1:0] ea, eb, ec, prod_w;

   assign sgn    = (op_in == OP_HIGH_S);
   assign ea     = {{XLEN{sgn & a[XLEN-1]}}, a};
   assign eb     = {{XLEN{sgn & b[XLEN-1]}}, b};
   assign ec     = {{XLEN{sgn & c[XLEN-1]}}, c};
   assign prod_w = ea * eb;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_op    <= OP_BAD;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) s1_op <= op_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_prod   <= '0;
         s1_addend <= '0;
      end else if (in_valid) begin
         s1_prod   <= prod_w;
         s1_addend <= ec;
      end
   end
endmodule

// File: rtl/imadd_sum_stage.sv
module imadd_sum_stage
   import imadd_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s1_valid,
   input  mac_op_e           s1_op,
   input  logic [2*XLEN-1:0] s1_prod,
   input  logic [2*XLEN-1:0] s1_addend,
   output logic              s2_valid,
   output logic              s2_illegal,
   output logic [XLEN-1:0]   s2_result
);
   logic [XLEN-1:0] sum_lo, sum_hi, pick;

   if (SPLIT_ADD) begin : g_split
      logic [XLEN:0] lo_w;
      assign lo_w   = {1'b0, s1_prod[XLEN-1:0]} + {1'b0, s1_addend[XLEN-1:0]};
      assign sum_lo = lo_w[XLEN-1:0];
      assign sum_hi = s1_prod[2*XLEN-1:XLEN] + s1_addend[2*XLEN-1:XLEN]
                      + {{(XLEN-1){1'b0}}, lo_w[XLEN]};
   end else begin : g_full
      logic [2*XLEN-1:0] full_w;
      assign full_w = s1_prod + s1_addend;
      assign sum_lo = full_w[XLEN-1:0];
      assign sum_hi = full_w[2*XLEN-1:XLEN];
   end

   assign pick = (s1_op == OP_LOW) ? sum_lo : sum_hi;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_valid   <= 1'b0;
         s2_illegal <= 1'b0;
         s2_result  <= '0;
      end else begin
         s2_valid   <= s1_valid;
         s2_illegal <= s1_valid && (s1_op == OP_BAD);
         if (s1_valid && (s1_op != OP_BAD)) s2_result <= pick;
      end
   end
endmodule

// File: rtl/imadd_unit.sv
module imadd_unit
   import imadd_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int INSN_W    = 32,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] insn,
   input  logic [XLEN-1:0]   opa,
   input  logic [XLEN-1:0]   opb,
   input  logic [XLEN-1:0]   opc,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [XLEN-1:0]   out_result
);
   mac_op_e             dec_op, s1_op;
   logic                s1_valid;
   logic [2*XLEN-1:0]   s1_prod, s1_addend;

   imadd_decode #(.INSN_W(INSN_W)) u_dec (
      .insn (insn),
      .op   (dec_op)
   );

   imadd_prod_stage #(.XLEN(XLEN)) u_s1 (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .op_in     (dec_op),
      .a         (opa),
      .b         (opb),
      .c         (opc),
      .s1_valid  (s1_valid),
      .s1_op     (s1_op),
      .s1_prod   (s1_prod),
      .s1_addend (s1_addend)
   );

   imadd_sum_stage #(.XLEN(XLEN), .SPLIT_ADD(SPLIT_ADD)) u_s2 (
      .clk        (clk),
      .rst        (rst),
      .s1_valid   (s1_valid),
      .s1_op      (s1_op),
      .s1_prod    (s1_prod),
      .s1_addend  (s1_addend),
      .s2_valid   (out_valid),
      .s2_illegal (out_illegal),
      .s2_result  (out_result)
   );
endmodule

// File: rtl/imadd_unit_chk.sv
module imadd_unit_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic [5:0]      pri_field,
   input logic            mid_valid,
   input logic            out_valid,
   input logic            out_illegal,
   input logic [XLEN-1:0] out_result
);
   // R1: completion two cycles after acceptance
   assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);

   // R1: nothing completes without a stage-1 entry
   assert_no_phantom_R1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(mid_valid));

   // R6: bad primary opcode reports illegal
   assert_bad_primary_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && pri_field != 6'd4) |-> ##2 (out_valid && out_illegal));

   // R6: illegal flag only with a strobe
   assert_illegal_strobe_R6: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> out_valid);

   // R6: illegal completion leaves the result alone
   assert_illegal_hold_R6: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> $stable(out_result));

   // R8: result steady between strobes
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_result));
endmodule

bind imadd_unit imadd_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .pri_field   (insn[INSN_W-1 -: 6]),
   .mid_valid   (s1_valid),
   .out_valid   (out_valid),
   .out_illegal (out_illegal),
   .out_result  (out_result)
);

// File: tb/imadd_unit_test.sv
module imadd_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] opa = '0, opb = '0, opc = '0;
   logic        out_valid, out_illegal;
   logic [63:0] out_result;

   imadd_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .opa(opa), .opb(opb), .opc(opc),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
   );

   always #5 clk = ~clk;

   typedef struct {
      logic        ill;
      logic [63:0] res;
      int          cyc;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0, failures = 0, cyc = 0;
   logic [63:0] model_last = '0;
   logic [63:0] seen_last = '0;
   bit          done = 0;

   localparam logic [5:0] XO_HS = 6'h30, XO_HU = 6'h31, XO_LO = 6'h33;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [5:0] pri, input logic [5:0] xo);
      return {pri, 20'h5a5a5, xo};
   endfunction

   // independent reference built from the requirements
   function automatic void model(input logic [31:0] w, input logic [63:0] a,
                                 input logic [63:0] b, input logic [63:0] c,
                                 output logic ill, output logic [63:0] r);
      logic [127:0] ea, eb, ec, s;
      ill = 1'b0;
      r   = model_last;
      if (w[31:26] != 6'd4 || !(w[5:0] == XO_HS || w[5:0] == XO_HU || w[5:0] == XO_LO)) begin
         ill = 1'b1;
      end else if (w[5:0] == XO_HS) begin
         ea = {{64{a[63]}}, a}; eb = {{64{b[63]}}, b}; ec = {{64{c[63]}}, c};
         s = ea * eb + ec; r = s[127:64];
      end else if (w[5:0] == XO_HU) begin
         ea = {64'd0, a}; eb = {64'd0, b}; ec = {64'd0, c};
         s = ea * eb + ec; r = s[127:64];
      end else begin
         r = a * b + c;
      end
   endfunction

   task automatic drive(input logic [31:0] w, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] c, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; insn = w; opa = a; opb = b; opc = c;
      model(w, a, b, c, e.ill, e.res);
      model_last = e.res;
      e.cyc = cyc + 2;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         insn = $urandom;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R1 unexpected strobe", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(cyc == e.cyc, {"R1 latency ", e.tag}, 64'(cyc), 64'(e.cyc));
               check(out_illegal == e.ill, {"R6 illegal flag ", e.tag},
                     64'(out_illegal), 64'(e.ill));
               check(out_result == e.res, e.tag, out_result, e.res);
            end
            seen_last = out_result;
         end else begin
            check(out_result == seen_last, "R8 hold", out_result, seen_last);
            check(out_illegal == 1'b0, "R6 idle illegal", 64'(out_illegal), 64'd0);
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R7 reset valid", 64'(out_valid), 64'd0);
      check(out_result == 64'd0, "R7 reset result", out_result, 64'd0);
      rst = 1'b0;

      drive(mk(6'd4, XO_HS), -64'sd3, 64'd5, 64'd7, "R2 signed high small");
      drive(mk(6'd4, XO_HU), -64'sd3, 64'd5, 64'd7, "R3 unsigned high small");
      drive(mk(6'd4, XO_LO), -64'sd3, 64'd5, 64'd7, "R4 low form");
      drive(mk(6'd4, XO_HU), '1, '1, '1, "R5 carry into high");
      drive(mk(6'd4, XO_HS), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
            '1, "R9 signed borrow corner");
      drive(mk(6'd5, XO_HS), 64'd9, 64'd9, 64'd9, "R6 bad primary");
      drive(mk(6'd4, 6'h32), 64'd9, 64'd9, 64'd9, "R6 bad extended 0x32");
      drive(mk(6'd4, XO_LO), 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321,
            64'h1111_1111_1111_1111, "R4 low form wide");
      drive(mk(6'd4, 6'h34), 64'd1, 64'd1, 64'd1, "R6 bad extended 0x34");
      idle(4);
      drive(mk(6'd4, XO_HS), 64'h7fff_ffff_ffff_ffff, -64'sd1, -64'sd1, "R2 signed negative");
      idle(1);
      drive(mk(6'd4, XO_HU), 64'h8000_0000_0000_0000, 64'd2, 64'd0, "R3 unsigned exact carry");

      for (int i = 0; i < 60; i++) begin
         logic [5:0] xo;
         case ($urandom_range(0, 3))
            0: xo = XO_HS;
            1: xo = XO_HU;
            2: xo = XO_LO;
            default: xo = 6'($urandom);
         endcase
         drive(mk(($urandom_range(0, 9) == 0) ? 6'd7 : 6'd4, xo),
               {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
               "R1 R2 R3 R4 random stream");
         if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
      end
      idle(6);
      check(sb.size() == 0, "R1 all completed", 64'(sb.size()), 64'd0);
      finish_run();
   end
endmodule